// File: doc/BRIEF.md
# H-Bridge PWM Gate Sequencer

This block turns a speed PWM input and a direction input into four gate-enable outputs. The outputs drive a full H-bridge of external N-channel MOSFETs: one high-side and one low-side switch on each of two legs, called leg A and leg B. The direction bit picks which leg carries the PWM. On that leg the high side conducts while the PWM is high, and the low side recirculates while it is low. The other leg keeps its low side on, so the active diagonal is high-side of one leg plus low-side of the other.

Each leg has its own dead-time sequencer. A switch being released drops on the next clock edge. The switch that takes over rises only after the leg has been fully off for a programmable number of cycles. This prevents shoot-through while still allowing a high side to stay on indefinitely (100% duty) in either direction. A direction change blanks all four gates and restarts the guard interval. Dropping the enable input gates all outputs off at once.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While rst_ni is low all four gate outputs are low, whatever the other inputs are.
- R2: With dir_i=0 and the bridge settled, hs_a_o equals pwm_i and ls_a_o equals its inverse; ls_b_o is continuously high and hs_b_o low. Output vector order used below is {hs_a_o, ls_a_o, hs_b_o, ls_b_o}, so forward settles at 1001 for pwm high and 0101 for pwm low.
- R3: With dir_i=1 the roles of the legs swap: leg B follows the PWM (settled 0110 for pwm high, 0101 for pwm low) and ls_a_o stays high.
- R4: A gate that must turn off goes low at the first rising clock edge after the input change that releases it.
- R5: A gate turns on only after its leg has had both gates low for dead_cnt_i+1 cycles: if its leg was released at edge k, it rises at edge k+dead_cnt_i+1. A PWM pulse shorter than this window never turns its switch on.
- R6: On each leg the high-side and low-side outputs are never high in the same cycle.
- R7: When en_i is low all four outputs are low in that same cycle, without waiting for a clock edge. When en_i returns high, each gate that should conduct rises after the full guard interval, counted from the last edge at which en_i was sampled low.
- R8: A change of dir_i forces all four gates low at the next edge. The new diagonal pair rises dead_cnt_i+1 edges after that.
- R9: With pwm_i held high and enable and direction stable, the active high-side gate stays on indefinitely (100% duty).
- R10: A dead_cnt_i of 0 still gives one cycle with both gates of a switching leg low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable; low forces all gates off |
| pwm_i | input | 1 | Speed PWM |
| dir_i | input | 1 | Rotation direction (0 leg A drives, 1 leg B drives) |
| dead_cnt_i | input | DT_W | Guard interval in clock cycles |
| hs_a_o | output | 1 | Leg A high-side gate enable |
| ls_a_o | output | 1 | Leg A low-side gate enable |
| hs_b_o | output | 1 | Leg B high-side gate enable |
| ls_b_o | output | 1 | Leg B low-side gate enable |

## Verification
The bench runs PWM edges in both directions. This separates the leg that switches from the leg that only holds its low side. A long high PWM level checks full duty, and a one-cycle PWM pulse shows that a pulse shorter than the guard window is swallowed. Direction flips made while the PWM is high show blanking of the whole bridge, as distinct from per-leg complementary switching. An enable drop and return separates immediate combinational gating from the restart of the guard count. The guard count is also run at zero to find the minimum single off cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_cmd_e;

  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hb_steer.sv
module hb_steer
  import hb_pkg::*;
(
  input  logic     pwm_i,
  input  logic     dir_i,
  output leg_cmd_e cmd_o [NUM_LEGS]
);
  localparam leg_cmd_e PWM_HI_CMD = LEG_HI;
  localparam leg_cmd_e PWM_LO_CMD = LEG_LO;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_cmd
    // driven leg chops; the other leg holds its low side as return path
    assign cmd_o[g] = (dir_i == 1'(g)) ? (pwm_i ? PWM_HI_CMD : PWM_LO_CMD) : LEG_LO;
  end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            kill_i,
  input  leg_cmd_e        cmd_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            hs_o,
  output logic            ls_o
);
  localparam int unsigned RUN_W = DT_W + 1;

  logic            hs_q, ls_q;
  logic [DT_W-1:0] cnt_q;
  logic            want_hs, want_ls;

  assign want_hs = (cmd_i == LEG_HI);
  assign want_ls = (cmd_i == LEG_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cnt_q <= '0;
    end else if (kill_i) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cnt_q <= '0;
    end else if (hs_q) begin
      if (!want_hs) begin
        hs_q  <= 1'b0;
        cnt_q <= '0;
      end
    end else if (ls_q) begin
      if (!want_ls) begin
        ls_q  <= 1'b0;
        cnt_q <= '0;
      end
    end else if (cnt_q >= dt_i) begin
      hs_q <= want_hs;
      ls_q <= want_ls;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // independent count of cycles with the leg fully off
  logic [RUN_W-1:0] off_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 off_run_q <= '0;
    else if (hs_q || ls_q)       off_run_q <= '0;
    else if (!(&off_run_q))      off_run_q <= off_run_q + 1'b1;
  end

  p_leg_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));

  p_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_q) || $rose(ls_q)) |-> ($past(off_run_q) >= {1'b0, $past(dt_i)}));

  p_hs_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_q && !want_hs) |=> !hs_q);

  p_ls_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_q && !want_ls) |=> !ls_q);

  p_hold_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_q && want_hs && !kill_i) |=> hs_q);
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hb_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            pwm_i,
  input  logic            dir_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            hs_a_o,
  output logic            ls_a_o,
  output logic            hs_b_o,
  output logic            ls_b_o
);
  logic                dir_q;
  logic                kill;
  logic [NUM_LEGS-1:0] hs_w, ls_w;
  leg_cmd_e            cmd_w [NUM_LEGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else         dir_q <= dir_i;
  end

  // a direction flip blanks the whole bridge for one edge, restarting every guard count
  assign kill = !en_i || (dir_i != dir_q);

  hb_steer u_steer (
    .pwm_i (pwm_i),
    .dir_i (dir_q),
    .cmd_o (cmd_w)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hb_leg #(.DT_W(DT_W)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .kill_i (kill),
      .cmd_i  (cmd_w[g]),
      .dt_i   (dead_cnt_i),
      .hs_o   (hs_w[g]),
      .ls_o   (ls_w[g])
    );
  end

  assign hs_a_o = hs_w[0] & en_i;
  assign ls_a_o = ls_w[0] & en_i;
  assign hs_b_o = hs_w[1] & en_i;
  assign ls_b_o = ls_w[1] & en_i;

  p_port_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_a_o && ls_a_o) && !(hs_b_o && ls_b_o));

  p_en_kill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (hs_w == '0 && ls_w == '0));

  p_dir_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_q) |-> (hs_w == '0 && ls_w == '0));

  p_reset_off_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (hs_w == '0 && ls_w == '0));
endmodule

// File: tb/sim_hbridge_gate_seq.sv
module sim_hbridge_gate_seq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned DT_W = 8;
  localparam int          WD_CYCLES = 100000;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0, pwm_i = 1'b0, dir_i = 1'b0;
  logic [DT_W-1:0] dead_cnt_i = '0;
  logic            hs_a, ls_a, hs_b, ls_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] q_exp [$];
  string      q_req [$];

  always #2.5 clk = ~clk;

  hbridge_gate_seq #(.DT_W(DT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .pwm_i(pwm_i), .dir_i(dir_i),
    .dead_cnt_i(dead_cnt_i),
    .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b)
  );

  function automatic logic [3:0] outs();
    return {hs_a, ls_a, hs_b, ls_b};
  endfunction

  // driver: apply inputs after the edge and queue the vector due at this cycle's falling edge
  task automatic cyc(input logic en, input logic pwm, input logic dir,
                     input logic [3:0] exp, input string req);
    @(posedge clk); #1;
    en_i = en; pwm_i = pwm; dir_i = dir;
    q_exp.push_back(exp);
    q_req.push_back(req);
  endtask

  task automatic seq(input logic en, input logic pwm, input logic dir,
                     input logic [3:0] first, input int mid_n, input logic [3:0] mid,
                     input int fin_n, input logic [3:0] fin, input string req);
    cyc(en, pwm, dir, first, req);
    repeat (mid_n) cyc(en, pwm, dir, mid, req);
    repeat (fin_n) cyc(en, pwm, dir, fin, req);
  endtask

  // monitor: pop and compare at the falling edge
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      n_chk++;
      if ((hs_a && ls_a) || (hs_b && ls_b)) begin
        n_fail++;
        $display("FAIL R6: leg overlap got %b expected no leg with both gates", outs());
      end
    end
    if (q_exp.size() > 0) begin
      logic [3:0] e;
      string r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      n_chk++;
      if (outs() !== e) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", r, outs(), e);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int d;
    d = 3;
    dead_cnt_i = DT_W'(d);
    en_i = 1'b1; pwm_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (outs() !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1: got %b expected %b", outs(), 4'b0000);
    end
    #1 en_i = 1'b0; pwm_i = 1'b0;
    @(posedge clk); #1 rst_ni = 1'b1;

    cyc(0, 0, 0, 4'b0000, "R7");
    cyc(0, 0, 0, 4'b0000, "R7");
    // forward, full duty
    seq(1, 1, 0, 4'b0000, d, 4'b0000, 4, 4'b1001, "R2");
    repeat (30) cyc(1, 1, 0, 4'b1001, "R9");
    // pwm falls: high side drops, low side after guard
    seq(1, 0, 0, 4'b1001, d + 1, 4'b0001, 6, 4'b0101, "R4");
    seq(1, 1, 0, 4'b0101, d + 1, 4'b0001, 6, 4'b1001, "R5");
    // direction flip with pwm high
    seq(1, 1, 1, 4'b1001, d + 1, 4'b0000, 6, 4'b0110, "R8");
    repeat (20) cyc(1, 1, 1, 4'b0110, "R9");
    seq(1, 0, 1, 4'b0110, d + 1, 4'b0100, 6, 4'b0101, "R3");
    // one-cycle pulse shorter than guard is swallowed
    cyc(1, 1, 1, 4'b0101, "R5");
    seq(1, 0, 1, 4'b0100, d, 4'b0100, 4, 4'b0101, "R5");
    seq(1, 1, 1, 4'b0101, d + 1, 4'b0100, 4, 4'b0110, "R3");
    // enable drop and return
    seq(0, 1, 1, 4'b0000, 3, 4'b0000, 0, 4'b0000, "R7");
    seq(1, 1, 1, 4'b0000, d, 4'b0000, 5, 4'b0110, "R7");
    // zero guard count
    @(posedge clk); #1 dead_cnt_i = '0;
    q_exp.push_back(4'b0110); q_req.push_back("R10");
    seq(1, 0, 1, 4'b0110, 1, 4'b0100, 4, 4'b0101, "R10");
    seq(1, 1, 1, 4'b0101, 1, 4'b0100, 4, 4'b0110, "R10");
    seq(1, 1, 0, 4'b0110, 1, 4'b0000, 4, 4'b1001, "R8");

    while (q_exp.size() > 0) @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule